// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block is the per-processor interrupt acceptance stage of an interrupt subsystem. It holds three 256-bit vector arrays: request, in-service and trigger mode. It also holds a task priority register and a spurious-vector register. From these it derives a processor priority and an interrupt-pending output. Requests arrive as a vector number with a trigger-mode flag and set bits in the arrays.

The processor takes an interrupt through an acknowledge handshake. In the same cycle, the block answers with either the highest pending vector or the spurious vector. The chosen vector moves from the request array to the in-service array on the clock edge that closes the handshake. An end-of-interrupt retires the highest in-service vector. It can be signalled by a strobe pin or by a register write.

A word-addressed register port gives read access to every field and the array words. Through the same port, software writes the task priority and the spurious-vector register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the task priority reads 0 and the spurious register reads 0xFF. Every word of the request, in-service and trigger-mode arrays reads 0, and `irq_pending_o` is low.
- R2: A request for vector v sets bit v&31 of request word v>>5. It sets the same trigger-mode bit when the level flag is 1 and clears it when the flag is 0. Both changes are visible from the cycle after the request.
- R3: The processor priority is the task priority when the task-priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it is that in-service class followed by four zero bits. An empty in-service array counts as class 0.
- R4: `irq_pending_o` is high only when spurious-register bit 8 is set and a request is pending. In addition, either the processor priority must be 0, or the class of the highest request must exceed the processor-priority class.
- R5: An acknowledge with a request pending returns the highest pending vector with the valid flag high, in the same cycle, unless R6 applies. From the next cycle that vector's request bit is clear and its in-service bit is set.
- R6: If the task priority is nonzero and the highest request vector is at most the task priority, an acknowledge returns the low byte of the spurious register with the valid flag high, and no array changes.
- R7: An acknowledge with no request pending drives the valid flag low and leaves every array unchanged.
- R8: An end-of-interrupt clears the highest set in-service bit. It is given by `eoi_i` or by any write to offset 0x0B. It has no effect when no in-service bit is set. When it coincides with an acknowledge, the bit set by the acknowledge survives.
- R9: The registers sit at these word offsets: 0x08 task priority (8 bits, read/write), 0x0A processor priority (read-only), 0x0F spurious vector (write keeps bits 8:0), in-service words at 0x10–0x17, trigger-mode words at 0x18–0x1F and request words at 0x20–0x27. Writes to the array and processor-priority offsets have no effect. Unmapped offsets and 0x0B read as 0.
- R10: A request that arrives in the same cycle as an acknowledge taking the same vector leaves the request bit set. The in-service bit is set as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Incoming request strobe |
| req_vec_i | input | 8 | Requested vector number |
| req_level_i | input | 1 | Trigger mode of the request: 0 edge, 1 level |
| ack_i | input | 1 | Acknowledge from the processor |
| ack_valid_o | output | 1 | Acknowledge answered with a vector |
| ack_vec_o | output | 8 | Vector returned to the acknowledge |
| eoi_i | input | 1 | End-of-interrupt strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_pending_o | output | 1 | Interrupt pending toward the processor |

## Verification
The acknowledge answer on `ack_valid_o` and `ack_vec_o` is combinational, so the bench samples it 1 ns after driving `ack_i` at the falling edge, before the rising edge that commits it. Every state effect appears one rising edge after its stimulus: request bits, in-service moves, end-of-interrupt, and register writes. These include the resulting `irq_pending_o` and processor priority. The bench therefore applies each operation for exactly one edge and releases it 1 ns after that edge. It then reads back the pending output and every register word in the quiet time that follows. At that point each result is compared against a reference model that the bench updates from the requirements in the same order: end-of-interrupt, then acknowledge, then request.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int VEC_W  = 8;
  localparam int CLS_W  = 4;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_TPR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PPR  = 8'h0A;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 8'h0B;
  localparam logic [ADDR_W-1:0] OFS_SPUR = 8'h0F;
  localparam logic [ADDR_W-1:0] OFS_ISR  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_TMR  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IRR  = 8'h20;
endpackage

// File: rtl/irq_hi_find.sv
module irq_hi_find #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_calc.sv
module irq_prio_calc #(
  parameter int VEC_W = irq_ctrl_pkg::VEC_W,
  parameter int CLS_W = irq_ctrl_pkg::CLS_W
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_hi_i,
  input  logic             irr_any_i,
  input  logic [VEC_W-1:0] irr_hi_i,
  input  logic             sw_en_i,
  output logic [VEC_W-1:0] ppr_o,
  output logic             pending_o
);
  localparam int SUB_W = VEC_W - CLS_W;

  logic [CLS_W-1:0] tpr_cls, isr_cls, ppr_cls, irr_cls;

  always_comb begin
    tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
    isr_cls = isr_any_i ? isr_hi_i[VEC_W-1 -: CLS_W] : '0;
    ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {SUB_W{1'b0}}};
    ppr_cls = ppr_o[VEC_W-1 -: CLS_W];
    irr_cls = irr_hi_i[VEC_W-1 -: CLS_W];
    pending_o = sw_en_i && irr_any_i && ((ppr_o == '0) || (irr_cls > ppr_cls));
  end
endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
  import irq_ctrl_pkg::*;
#(
  parameter int VW = irq_ctrl_pkg::VEC_W,
  parameter int WW = irq_ctrl_pkg::WORD_W
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [VW-1:0]        tpr_i,
  input  logic [VW-1:0]        ppr_i,
  input  logic [VW:0]          spur_i,
  input  logic [(1<<VW)-1:0]   isr_i,
  input  logic [(1<<VW)-1:0]   tmr_i,
  input  logic [(1<<VW)-1:0]   irr_i,
  output logic [WW-1:0]        rdata_o
);
  localparam int NUM_WORDS = (1 << VW) / WW;
  localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [ADDR_W-1:0] NW = ADDR_W'(NUM_WORDS);

  function automatic logic in_bank(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
    return (a >= base) && (a < base + NW);
  endfunction

  logic [WSEL_W-1:0] sel_isr, sel_tmr, sel_irr;

  always_comb begin
    sel_isr = WSEL_W'(addr_i - OFS_ISR);
    sel_tmr = WSEL_W'(addr_i - OFS_TMR);
    sel_irr = WSEL_W'(addr_i - OFS_IRR);
    rdata_o = '0;
    if (addr_i == OFS_TPR)                rdata_o = WW'(tpr_i);
    else if (addr_i == OFS_PPR)           rdata_o = WW'(ppr_i);
    else if (addr_i == OFS_SPUR)          rdata_o = WW'(spur_i);
    else if (in_bank(addr_i, OFS_ISR))    rdata_o = isr_i[sel_isr*WW +: WW];
    else if (in_bank(addr_i, OFS_TMR))    rdata_o = tmr_i[sel_tmr*WW +: WW];
    else if (in_bank(addr_i, OFS_IRR))    rdata_o = irr_i[sel_irr*WW +: WW];
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int VW = irq_ctrl_pkg::VEC_W,
  parameter int WW = irq_ctrl_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VW-1:0]     req_vec_i,
  input  logic              req_level_i,
  input  logic              ack_i,
  output logic              ack_valid_o,
  output logic [VW-1:0]     ack_vec_o,
  input  logic              eoi_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WW-1:0]     reg_wdata_i,
  output logic [WW-1:0]     reg_rdata_o,
  output logic              irq_pending_o
);
  localparam int NUM_VEC = 1 << VW;
  localparam int SPUR_W  = VW + 1;
  localparam logic [SPUR_W-1:0] SPUR_RST = {1'b0, {VW{1'b1}}};

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  logic [VW-1:0]      tpr_q;
  logic [SPUR_W-1:0]  spur_q;

  logic          irr_any, isr_any;
  logic [VW-1:0] irr_hi, isr_hi, ppr;
  logic          ack_spur, ack_take, eoi_do;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[WW-1:SPUR_W];

  irq_hi_find #(.N(NUM_VEC), .IW(VW)) i_irr_find (
    .vec_i(irr_q), .any_o(irr_any), .idx_o(irr_hi)
  );

  irq_hi_find #(.N(NUM_VEC), .IW(VW)) i_isr_find (
    .vec_i(isr_q), .any_o(isr_any), .idx_o(isr_hi)
  );

  irq_prio_calc #(.VEC_W(VW), .CLS_W(CLS_W)) i_prio (
    .tpr_i     (tpr_q),
    .isr_any_i (isr_any),
    .isr_hi_i  (isr_hi),
    .irr_any_i (irr_any),
    .irr_hi_i  (irr_hi),
    .sw_en_i   (spur_q[VW]),
    .ppr_o     (ppr),
    .pending_o (irq_pending_o)
  );

  irq_reg_read #(.VW(VW), .WW(WW)) i_rd (
    .addr_i  (reg_addr_i),
    .tpr_i   (tpr_q),
    .ppr_i   (ppr),
    .spur_i  (spur_q),
    .isr_i   (isr_q),
    .tmr_i   (tmr_q),
    .irr_i   (irr_q),
    .rdata_o (reg_rdata_o)
  );

  // Acknowledge answer is combinational; the move commits at the next edge.
  assign ack_spur    = (tpr_q != '0) && (irr_hi <= tpr_q);
  assign ack_valid_o = ack_i && irr_any;
  assign ack_take    = ack_valid_o && !ack_spur;
  assign ack_vec_o   = ack_spur ? spur_q[VW-1:0] : irr_hi;
  assign eoi_do      = (eoi_i || (reg_we_i && reg_addr_i == OFS_EOI)) && isr_any;

  // Order: EOI clear, acknowledge move, then request set (set wins).
  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (eoi_do) isr_d[isr_hi] = 1'b0;
    if (ack_take) begin
      irr_d[irr_hi] = 1'b0;
      isr_d[irr_hi] = 1'b1;
    end
    if (req_valid_i) begin
      irr_d[req_vec_i] = 1'b1;
      tmr_d[req_vec_i] = req_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      tmr_q  <= '0;
      tpr_q  <= '0;
      spur_q <= SPUR_RST;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
      if (reg_we_i && reg_addr_i == OFS_TPR)  tpr_q  <= reg_wdata_i[VW-1:0];
      if (reg_we_i && reg_addr_i == OFS_SPUR) spur_q <= reg_wdata_i[SPUR_W-1:0];
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int VW = 8,
  parameter int CW = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [VW-1:0]     req_vec_i,
  input logic              req_level_i,
  input logic              ack_i,
  input logic              ack_valid_o,
  input logic [VW-1:0]     ack_vec_o,
  input logic              eoi_i,
  input logic              eoi_do,
  input logic [(1<<VW)-1:0] irr_q,
  input logic [(1<<VW)-1:0] isr_q,
  input logic [(1<<VW)-1:0] tmr_q,
  input logic [VW-1:0]     tpr_q,
  input logic [VW:0]       spur_q,
  input logic [VW-1:0]     ppr,
  input logic              irq_pending_o
);
  p_req_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> irr_q[$past(req_vec_i)] && (tmr_q[$past(req_vec_i)] == $past(req_level_i)));

  p_ppr_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr[VW-1 -: CW] >= tpr_q[VW-1 -: CW]);

  p_ppr_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppr[VW-CW-1:0] != '0) |-> (ppr == tpr_q));

  p_pend_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spur_q[VW] |-> !irq_pending_o);

  p_ack_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_o && tpr_q == '0 && !req_valid_i) |=>
      isr_q[$past(ack_vec_o)] && !irr_q[$past(ack_vec_o)]);

  p_ack_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_valid_o && !req_valid_i && !eoi_do) |=> $stable(irr_q) && $stable(isr_q));

  p_eoi_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_q == '0 && !ack_i) |=> (isr_q == '0));

  p_req_ack_same_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_o && req_valid_i && req_vec_i == ack_vec_o) |=> irr_q[$past(req_vec_i)]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VW(VW), .CW(irq_ctrl_pkg::CLS_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_vec_i     (req_vec_i),
  .req_level_i   (req_level_i),
  .ack_i         (ack_i),
  .ack_valid_o   (ack_valid_o),
  .ack_vec_o     (ack_vec_o),
  .eoi_i         (eoi_i),
  .eoi_do        (eoi_do),
  .irr_q         (irr_q),
  .isr_q         (isr_q),
  .tmr_q         (tmr_q),
  .tpr_q         (tpr_q),
  .spur_q        (spur_q),
  .ppr           (ppr),
  .irq_pending_o (irq_pending_o)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_vec_i = '0;
  logic        req_level_i = 1'b0;
  logic        ack_i = 1'b0;
  logic        ack_valid_o;
  logic [7:0]  ack_vec_o;
  logic        eoi_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_pending_o;

  int errors = 0;
  int checks = 0;

  bit [255:0] m_irr, m_isr, m_tmr;
  bit [7:0]   m_tpr;
  bit [8:0]   m_spur;

  always #5 clk_i = ~clk_i;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_vec_i, .req_level_i,
    .ack_i, .ack_valid_o, .ack_vec_o, .eoi_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_pending_o
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic int hi(input bit [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int ppr_m();
    int ic, tc;
    tc = m_tpr >> 4;
    ic = (hi(m_isr) < 0) ? 0 : (hi(m_isr) >> 4);
    return (tc >= ic) ? int'(m_tpr) : (ic << 4);
  endfunction

  function automatic bit pend_m();
    int hv, p;
    hv = hi(m_irr);
    p  = ppr_m();
    return m_spur[8] && hv >= 0 && (p == 0 || (hv >> 4) > (p >> 4));
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic verify(input string tag);
    logic [31:0] d;
    chk(tag, "pending", irq_pending_o, pend_m());
    rd(8'h08, d); chk(tag, "tpr", d, m_tpr);
    rd(8'h0A, d); chk(tag, "ppr", d, ppr_m());
    rd(8'h0F, d); chk(tag, "spur", d, m_spur);
    for (int w = 0; w < 8; w++) begin
      rd(8'h10 + 8'(w), d); chk(tag, $sformatf("isr[%0d]", w), d, m_isr[w*32 +: 32]);
      rd(8'h18 + 8'(w), d); chk(tag, $sformatf("tmr[%0d]", w), d, m_tmr[w*32 +: 32]);
      rd(8'h20 + 8'(w), d); chk(tag, $sformatf("irr[%0d]", w), d, m_irr[w*32 +: 32]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0; m_spur = 9'h0FF;
  endtask

  // One edge of request / acknowledge / EOI; model order: EOI, ack, request.
  task automatic op(input bit rq, input int v, input bit lv, input bit ak, input bit eo, input string tag);
    int hv, hs;
    bit spur;
    @(negedge clk_i);
    req_valid_i = rq; req_vec_i = 8'(v); req_level_i = lv; ack_i = ak; eoi_i = eo;
    hv = hi(m_irr);
    hs = hi(m_isr);
    spur = (m_tpr != 0) && (hv <= int'(m_tpr));
    if (ak) begin
      #1;
      chk(tag, "ack_valid", ack_valid_o, (hv >= 0));
      if (hv >= 0) chk(tag, "ack_vec", ack_vec_o, spur ? m_spur[7:0] : 8'(hv));
    end
    @(posedge clk_i);
    #1;
    req_valid_i = 1'b0; ack_i = 1'b0; eoi_i = 1'b0;
    if (eo && hs >= 0) m_isr[hs] = 1'b0;
    if (ak && hv >= 0 && !spur) begin
      m_irr[hv] = 1'b0;
      m_isr[hv] = 1'b1;
    end
    if (rq) begin
      m_irr[v] = 1'b1;
      m_tmr[v] = lv;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int hs;
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    hs = hi(m_isr);
    @(posedge clk_i);
    #1;
    reg_we_i = 1'b0;
    if (a == 8'h08) m_tpr = d[7:0];
    if (a == 8'h0F) m_spur = d[8:0];
    if (a == 8'h0B && hs >= 0) m_isr[hs] = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int v, sel;

    // R1: reset values
    do_reset();
    #1;
    chk("R1", "pending after reset", irq_pending_o, 1'b0);
    verify("R1");

    // R9: spurious write masked to 9 bits, enables delivery
    wr(8'h0F, 32'hFFFF_FFFF);
    verify("R9");

    // R2 R5 R8: sweep every vector through request, ack, EOI
    for (int i = 0; i < 256; i++) begin
      op(1'b1, i, i[0], 1'b0, 1'b0, "R2"); verify("R2");
      op(1'b0, 0, 1'b0, 1'b1, 1'b0, "R5"); verify("R5");
      op(1'b0, 0, 1'b0, 1'b0, 1'b1, "R8"); verify("R8");
    end

    // R3 R4 R6: task-priority class against request class, with an in-service class
    for (int tc = 0; tc < 16; tc++) begin
      for (int rc = 0; rc < 16; rc++) begin
        do_reset();
        wr(8'h0F, 32'h0000_01A5);
        v = ((rc * 7) % 16) << 4;
        op(1'b1, v, 1'b0, 1'b0, 1'b0, "R3");
        op(1'b0, 0, 1'b0, 1'b1, 1'b0, "R3");
        wr(8'h08, (tc << 4) | (rc & 15));
        op(1'b1, (rc << 4) | 3, 1'b1, 1'b0, 1'b0, "R4");
        verify("R3 R4");
        op(1'b0, 0, 1'b0, 1'b1, 1'b0, "R6");
        verify("R6");
      end
    end

    // R6: spurious disabled bit also blocks pending (R4)
    do_reset();
    op(1'b1, 200, 1'b0, 1'b0, 1'b0, "R4");
    verify("R4 disabled");
    wr(8'h0F, 32'h0000_0133);
    wr(8'h08, 32'h0000_00C8);
    op(1'b0, 0, 1'b0, 1'b1, 1'b0, "R6 equal");
    verify("R6 equal");
    wr(8'h08, 32'h0000_00C7);
    op(1'b0, 0, 1'b0, 1'b1, 1'b0, "R6 above");
    verify("R6 above");

    // R7: ack with empty request array
    do_reset();
    wr(8'h0F, 32'h0000_01FF);
    op(1'b1, 90, 1'b0, 1'b0, 1'b0, "R7");
    op(1'b0, 0, 1'b0, 1'b1, 1'b0, "R7");
    op(1'b0, 0, 1'b0, 1'b1, 1'b0, "R7");
    verify("R7");

    // R8: EOI by register write, then with in-service empty
    wr(8'h0B, 32'h0);
    verify("R8 reg");
    wr(8'h0B, 32'h0);
    op(1'b0, 0, 1'b0, 1'b0, 1'b1, "R8 empty");
    verify("R8 empty");

    // R9: read-only offsets and unmapped reads
    op(1'b1, 77, 1'b1, 1'b0, 1'b0, "R9");
    wr(8'h12, 32'hFFFF_FFFF);
    wr(8'h1A, 32'hFFFF_FFFF);
    wr(8'h22, 32'h0);
    wr(8'h0A, 32'hFFFF_FFFF);
    wr(8'h08, 32'hABCD_1234);
    verify("R9 ro");
    @(negedge clk_i);
    rd(8'h0B, d); chk("R9", "eoi read", d, 32'h0);
    rd(8'h30, d); chk("R9", "unmapped read", d, 32'h0);
    rd(8'h28, d); chk("R9", "past request bank", d, 32'h0);

    // R10: request and ack of the same vector in one cycle
    do_reset();
    wr(8'h0F, 32'h0000_01FF);
    op(1'b1, 150, 1'b0, 1'b0, 1'b0, "R10");
    op(1'b1, 150, 1'b1, 1'b1, 1'b0, "R10");
    verify("R10");
    chk("R10", "irr bit 150", m_irr[150], 1'b1);

    // Mixed sequence against the model
    do_reset();
    wr(8'h0F, 32'h0000_0100);
    for (int n = 0; n < 2500; n++) begin
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2, 3: op(1'b1, $urandom_range(0, 255), 1'($urandom_range(0, 1)), 1'b0, 1'b0, "R2");
        4, 5:       op(1'b0, 0, 1'b0, 1'b1, 1'b0, "R5");
        6:          op(1'b0, 0, 1'b0, 1'b0, 1'b1, "R8");
        7:          wr(8'h08, 32'($urandom_range(0, 255)));
        8: begin
          d = $urandom;
          if ($urandom_range(0, 3) != 0) d[8] = 1'b1;
          wr(8'h0F, d);
        end
        default: begin
          v = (hi(m_irr) >= 0 && $urandom_range(0, 1) == 1) ? hi(m_irr) : int'($urandom_range(0, 255));
          op(1'b1, v, 1'($urandom_range(0, 1)), 1'b1, 1'($urandom_range(0, 1)), "R10");
        end
      endcase
      verify("R4 mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule